// File: doc/BRIEF.md
# Three-Multiplier Complex Multiply-Accumulate Unit

This block multiplies two complex operands, a = a_re + j·a_im and b = b_re + j·b_im, and adds the product into a pair of running sums, one real and one imaginary. A new operand pair can enter on every clock. The complex product is built from three real multiplications rather than four. A shared cross term, b_im·(a_re − a_im), is formed on its own pipeline. Two legs then each form one more pre-added product. The real leg forms a_re·(b_re − b_im) and the imaginary leg forms a_im·(b_re + b_im). Each leg adds the shared term and its own running sum in one final adder, so accumulation adds no pipeline stage of its own.

The operand stream uses a valid/ready handshake. The result stream uses the same handshake, with back-pressure. The whole pipeline advances only on cycles when the result consumer is ready, so `in_ready` is simply `out_ready`. While `out_ready` is low, nothing moves, no operand is taken, and the presented result is held. A pair sent with `in_clear` high starts a new sum from that pair's product. Pipeline slots that carry no operand leave both sums untouched and produce no result beat.

Top module: `cplx3m_mac`

## Requirements
- R1: `in_ready` equals `out_ready` in every cycle. An operand pair is taken at a rising edge where `in_valid` and `in_ready` are both high. A result is delivered at a rising edge where `out_valid` and `out_ready` are both high.
- R2: The path has six register stages. A pair taken at edge e raises `out_valid` after edge e+5, provided `out_ready` stayed high through those edges, and `out_valid` is low after edges e+1 to e+4 when no other pair was taken in between.
- R3: Each taken pair adds a_re·b_re − a_im·b_im to `acc_re` and a_re·b_im + a_im·b_re to `acc_im`. The sums are signed two's complement of width ACC_W = 2·DW + 2 + ceil(log2(MAX_ACC)) and wrap modulo 2^ACC_W.
- R4: A pair taken with `in_clear` high replaces both sums with that pair's own product terms. Earlier history is discarded.
- R5: When `out_valid` is low, both sums are unchanged from the previous cycle.
- R6: In the cycle after a rising edge with `out_ready` low, `out_valid`, `acc_re` and `acc_im` all hold the values they had before that edge.
- R7: Synchronous active-low reset clears `out_valid` and both sums to zero.
- R8: The sums are exact for the most negative operand value −2^(DW−1) in any operand position, combined with either extreme. No intermediate pre-adder or product overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Operand pair can be taken (equals out_ready) |
| in_clear | input | 1 | Restart both sums with this pair's product |
| a_re | input | DW | Real part of operand a, signed |
| a_im | input | DW | Imaginary part of operand a, signed |
| b_re | input | DW | Real part of operand b, signed |
| b_im | input | DW | Imaginary part of operand b, signed |
| out_valid | output | 1 | Updated sums present |
| out_ready | input | 1 | Consumer takes the result; advances the pipeline |
| acc_re | output | ACC_W | Real running sum, signed |
| acc_im | output | ACC_W | Imaginary running sum, signed |

## Verification
A fault in a pre-adder, in a multiplier, or in the delay that aligns the legs with the shared term corrupts the very first result beat after the faulty pair, six edges later. Because the sums accumulate, that error then persists in every later beat until the next clear. A misaligned clear or valid bit shows either as a sum that fails to restart or as a beat appearing one edge early or late. A broken stall shows as sums or `out_valid` changing while `out_ready` is low, in the first cycle after the stalled edge. The bench compares every delivered beat against a four-multiplier reference sum. Its stimulus includes the most negative operands and random bursts that mix clears, gaps and stalls.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  function automatic int guard_bits(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

  typedef struct packed {
    logic vld;
    logic clr;
  } ctl_t;

endpackage

// File: rtl/cmac_pipe.sv
module cmac_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[i] <= '0;
      end else if (en) begin
        if (i == 0) stg[i] <= d;
        else        stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/cmac_cross_term.sv
module cmac_cross_term #(
  parameter int DW = 16,
  localparam int PW = 2*DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_im,
  output logic signed [PW-1:0] p1
);

  logic signed [DW:0]   are_x, aim_x;
  logic signed [DW:0]   dif_q;
  logic signed [DW-1:0] bim_q;
  logic signed [PW-1:0] mul_q, prd_q, prd_d;

  assign are_x = a_re;
  assign aim_x = a_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dif_q <= '0;
      bim_q <= '0;
      mul_q <= '0;
      prd_q <= '0;
      prd_d <= '0;
    end else if (en) begin
      dif_q <= are_x - aim_x;
      bim_q <= b_im;
      mul_q <= dif_q * bim_q;
      prd_q <= mul_q;
      prd_d <= prd_q;
    end
  end

  assign p1 = prd_d;

endmodule

// File: rtl/cmac_leg.sv
module cmac_leg #(
  parameter int DW       = 16,
  parameter int ACW      = 44,
  parameter bit NEGATE_B = 1'b1,
  localparam int PW = 2*DW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [DW-1:0]  x,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  input  logic signed [PW-1:0]  p1,
  input  logic                  vld,
  input  logic                  clr,
  output logic signed [ACW-1:0] acc
);

  logic signed [DW:0]    bre_x, bim_x, pre_c;
  logic signed [DW:0]    pre_q;
  logic signed [DW-1:0]  x_q;
  logic signed [PW-1:0]  mul_q;
  logic signed [ACW-1:0] mul_e, p1_e, base, nxt;

  assign bre_x = b_re;
  assign bim_x = b_im;

  if (NEGATE_B) begin : g_sub
    assign pre_c = bre_x - bim_x;
  end else begin : g_add
    assign pre_c = bre_x + bim_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      x_q   <= '0;
      mul_q <= '0;
    end else if (en) begin
      pre_q <= pre_c;
      x_q   <= x;
      mul_q <= pre_q * x_q;
    end
  end

  assign mul_e = mul_q;
  assign p1_e  = p1;

  always_comb begin
    base = clr ? '0 : acc;
    nxt  = base + mul_e + p1_e;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          acc <= '0;
    else if (en && vld)  acc <= nxt;
  end

endmodule

// File: rtl/cplx3m_mac.sv
module cplx3m_mac #(
  parameter int DW      = 16,
  parameter int MAX_ACC = 1024,
  localparam int ACW    = 2*DW + 2 + cmac_pkg::guard_bits(MAX_ACC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_clear,
  input  logic signed [DW-1:0]  a_re,
  input  logic signed [DW-1:0]  a_im,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic signed [ACW-1:0] acc_re,
  output logic signed [ACW-1:0] acc_im
);

  import cmac_pkg::*;

  localparam int PW = 2*DW + 1;
  localparam int OW = 4*DW;

  logic                 en, fire;
  logic signed [DW-1:0] are1, aim1, bre1, bim1;
  logic signed [DW-1:0] are3, aim3, bre3, bim3;
  logic [OW-1:0]        ops1, ops3;
  ctl_t                 ctl1, ctl5;
  logic [1:0]           ctl5_bits;
  logic signed [PW-1:0] p1_s5;

  assign en       = out_ready;
  assign in_ready = en;
  assign fire     = in_valid && in_ready;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      are1 <= '0; aim1 <= '0; bre1 <= '0; bim1 <= '0;
      ctl1 <= '0;
    end else if (en) begin
      are1 <= a_re; aim1 <= a_im; bre1 <= b_re; bim1 <= b_im;
      ctl1.vld <= in_valid;
      ctl1.clr <= in_valid && in_clear;
    end
  end

  // two-cycle alignment of leg operands with the shared term
  assign ops1 = {are1, aim1, bre1, bim1};

  cmac_pipe #(.W(OW), .DEPTH(2)) u_align (
    .clk(clk), .rst_n(rst_n), .en(en), .d(ops1), .q(ops3)
  );

  assign are3 = ops3[4*DW-1:3*DW];
  assign aim3 = ops3[3*DW-1:2*DW];
  assign bre3 = ops3[2*DW-1:DW];
  assign bim3 = ops3[DW-1:0];

  // control travels stage 1 -> stage 5
  cmac_pipe #(.W(2), .DEPTH(4)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .d(ctl1), .q(ctl5_bits)
  );
  assign ctl5 = ctl5_bits;

  cmac_cross_term #(.DW(DW)) u_cross (
    .clk(clk), .rst_n(rst_n), .en(en),
    .a_re(are1), .a_im(aim1), .b_im(bim1), .p1(p1_s5)
  );

  cmac_leg #(.DW(DW), .ACW(ACW), .NEGATE_B(1'b1)) u_leg_re (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x(are3), .b_re(bre3), .b_im(bim3), .p1(p1_s5),
    .vld(ctl5.vld), .clr(ctl5.clr), .acc(acc_re)
  );

  cmac_leg #(.DW(DW), .ACW(ACW), .NEGATE_B(1'b0)) u_leg_im (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x(aim3), .b_re(bre3), .b_im(bim3), .p1(p1_s5),
    .vld(ctl5.vld), .clr(ctl5.clr), .acc(acc_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)  out_valid <= 1'b0;
    else if (en) out_valid <= ctl5.vld;
  end

  // R2: a taken pair surfaces after six advancing edges
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire,6) && $past(rst_n,6) &&
     $past(out_ready,1) && $past(out_ready,2) && $past(out_ready,3) &&
     $past(out_ready,4) && $past(out_ready,5) &&
     $past(rst_n,1) && $past(rst_n,2) && $past(rst_n,3) &&
     $past(rst_n,4) && $past(rst_n,5))
    |-> out_valid);

  // R5: no result beat means no change to the sums
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_valid) |-> ($stable(acc_re) && $stable(acc_im)));

  // R6: a stalled edge changes nothing visible
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(out_ready))
    |-> ($stable(out_valid) && $stable(acc_re) && $stable(acc_im)));

  // R7: state straight after reset
  p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!out_valid && acc_re == '0 && acc_im == '0));

endmodule

// File: tb/cplx3m_mac_test.sv
module cplx3m_mac_test;

  localparam int DW      = 16;
  localparam int MAX_ACC = 1024;
  localparam int ACW     = 2*DW + 2 + $clog2(MAX_ACC);
  localparam int NEG     = -(1 << (DW-1));
  localparam int POS     = (1 << (DW-1)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_clear, out_valid, out_ready;
  logic signed [DW-1:0]  a_re, a_im, b_re, b_im;
  logic signed [ACW-1:0] acc_re, acc_im;

  int total = 0;
  int bad   = 0;

  logic signed [ACW-1:0] ref_re, ref_im;
  logic signed [ACW-1:0] q_re[$];
  logic signed [ACW-1:0] q_im[$];
  logic                  prev_rdy, prev_ov;
  logic signed [ACW-1:0] prev_re, prev_im;
  logic                  started = 1'b0;

  always #4 clk = ~clk;

  cplx3m_mac #(.DW(DW), .MAX_ACC(MAX_ACC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_clear(in_clear), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .acc_re(acc_re), .acc_im(acc_im)
  );

  function automatic longint prod_re(int ar, int ai, int br, int bi);
    return longint'(ar) * longint'(br) - longint'(ai) * longint'(bi);
  endfunction

  function automatic longint prod_im(int ar, int ai, int br, int bi);
    return longint'(ar) * longint'(bi) + longint'(ai) * longint'(br);
  endfunction

  task automatic check(input bit ok, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one cycle: drive at the falling edge, then check what the design shows
  task automatic step(input bit v, input bit clr, input int ar, input int ai,
                      input int br, input int bi, input bit rdy);
    longint pr, pi;
    @(negedge clk);
    in_valid  = v;
    in_clear  = clr;
    a_re      = DW'(ar);
    a_im      = DW'(ai);
    b_re      = DW'(br);
    b_im      = DW'(bi);
    out_ready = rdy;
    #1;
    check(in_ready == rdy, "R1 in_ready", longint'(in_ready), longint'(rdy));
    if (started) begin
      if (!prev_rdy) begin
        check(out_valid == prev_ov, "R6 out_valid held", longint'(out_valid), longint'(prev_ov));
        check(acc_re == prev_re && acc_im == prev_im, "R6 sums held",
              longint'(acc_re), longint'(prev_re));
      end
      if (!out_valid)
        check(acc_re == prev_re && acc_im == prev_im, "R5 sums idle",
              longint'(acc_re), longint'(prev_re));
    end
    if (out_valid && rdy) begin
      if (q_re.size() == 0) begin
        check(1'b0, "R2 unexpected beat", 1, 0);
      end else begin
        logic signed [ACW-1:0] er, ei;
        er = q_re.pop_front();
        ei = q_im.pop_front();
        // R3 sums, R4 restart on clear, R8 extreme operands
        check(acc_re == er, "R3 R4 R8 real sum", longint'(acc_re), longint'(er));
        check(acc_im == ei, "R3 R4 R8 imag sum", longint'(acc_im), longint'(ei));
      end
    end
    if (v && rdy) begin
      pr = prod_re(ar, ai, br, bi);
      pi = prod_im(ar, ai, br, bi);
      ref_re = clr ? ACW'(pr) : ref_re + ACW'(pr);
      ref_im = clr ? ACW'(pi) : ref_im + ACW'(pi);
      q_re.push_back(ref_re);
      q_im.push_back(ref_im);
    end
    prev_rdy = rdy;
    prev_ov  = out_valid;
    prev_re  = acc_re;
    prev_im  = acc_im;
    started  = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  function automatic int pick_op();
    int r;
    r = int'($urandom % 8);
    if (r == 0) return NEG;
    if (r == 1) return POS;
    return int'($urandom % (1 << DW)) + NEG;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C3A1));
    ref_re = '0; ref_im = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_clear = 1'b0; out_ready = 1'b1;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(!out_valid, "R7 out_valid in reset", longint'(out_valid), 0);
    check(acc_re == 0 && acc_im == 0, "R7 sums in reset", longint'(acc_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && acc_re == 0, "R7 after release", longint'(acc_re), 0);

    // R2: latency of one isolated pair
    step(1, 1, 3, -5, 7, 11, 1);
    for (int i = 1; i <= 6; i++) begin
      step(0, 0, 0, 0, 0, 0, 1);
      if (i < 6) check(!out_valid, "R2 early beat", longint'(out_valid), 0);
      else       check(out_valid,  "R2 beat after six edges", longint'(out_valid), 1);
    end
    idle(2);

    // R4: continue then restart
    step(1, 0, 100, 200, -300, 400, 1);
    step(1, 1, -9, 4, 2, -8, 1);
    step(1, 0, 1, 1, 1, 1, 1);
    idle(8);

    // R8: most negative operand corners
    step(1, 1, NEG, NEG, NEG, NEG, 1);
    step(1, 1, NEG, POS, POS, NEG, 1);
    step(1, 1, POS, NEG, NEG, POS, 1);
    step(1, 1, NEG, POS, NEG, POS, 1);
    step(1, 0, NEG, NEG, NEG, NEG, 1);
    step(1, 0, NEG, NEG, NEG, NEG, 1);
    idle(8);

    // R6: stall with a beat waiting
    step(1, 1, 12, 34, 56, 78, 1);
    idle(5);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 9, 9, 9, 9, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    idle(8);

    // random bursts with clears, gaps and stalls
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, ($urandom % 16) == 0,
           pick_op(), pick_op(), pick_op(), pick_op(),
           ($urandom % 5) != 0);
    end
    idle(12);
    check(q_re.size() == 0, "R2 beats missing", longint'(q_re.size()), 0);
    finish_run();
  end

endmodule